// File: doc/BRIEF.md
# Scanout Line Address Generator

This block works out where each display line begins in video memory while a frame is scanned out. It sits beside the raster timing logic. That logic pulses a frame-start strobe once per field and a line-start strobe once per active output line. In reply the block returns the byte address of the row to fetch, how many 32-bit words that row holds, and the decoded pixel format and display resolution for the fetch and unpack stages further down.

Three memory layouts are supported:

- **Progressive:** one base address and a fixed row stride.
- **Field-based interlace:** the base address is taken from one of two field bases. The choice follows the current field, and it flips when the raster has already passed the retrace start line at the moment the frame strobe arrives.
- **Woven interlace:** both fields sit in one double-height frame. This mode applies when the line width in words equals the modulo.

An optional line-doubling mode shows every row address on two output lines. All configuration is sampled on the frame-start strobe, so register writes made during a frame only take effect on the next one.

Top module: `scan_addr_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is driven to zero: `line_addr`, `line_valid`, `line_words`, `pix_fmt`, `hres`, `vres`, `out_en` and `border_force`.
- R2: The size word has three fields:
  - `size_word[29:20]` is the modulo M.
  - `size_word[19:10]` is the number of lines per field minus 1, giving L.
  - `size_word[9:0]` is the number of words per line minus 1, giving W.

  Outside the woven case, row n of a frame begins at `(base_a & 0xFFFFFC) + n*(W+M-1)*4`, taken modulo 2^24. The frame has L rows, and `line_words` equals W. Every presented address is word aligned.
- R3: With `interlace` set and W not equal to M, the field base is `base_a` (masked to 0xFFFFFC) when the effective field is odd, and `base_b` (masked the same way) when it is even. The input `field_odd` = 1 means odd.
- R4: In the case of R3, the effective field is the inverse of `field_odd` whenever `line_pos >= retrace_line` at the frame-start strobe.
- R5: With `interlace` set and W equal to M, rows are read from masked `base_a` with a stride of W*4 bytes, and the frame has 2*L rows. With `interlace` clear, W equal to M still uses the stride rule of R2.
- R6: After the frame's last row has been presented, further line strobes give `line_valid` = 0 until the next frame-start strobe.
- R7: When `mode_word[1]` is set, every row address is presented on two consecutive line strobes before the address advances. The frame then yields twice as many valid lines.
- R8: `pix_fmt` = `mode_word[3:2]`, where 0 is 16-bit 1555, 1 is 16-bit 565, 2 is packed 24-bit and 3 is 32-bit. The value of `hres` depends on the format:
  - formats 0 and 1: W*2
  - format 2: floor(W*4/3)
  - format 3: W

  `vres` is the frame's row count. A value of 8 or less is replaced by 640 for `hres` and by 480 for `vres`.
- R9: `out_en` = `mode_word[0]` AND `vid_out`. `border_force` = `out_en` AND `aux_cfg[3]`.
- R10: The configuration inputs are sampled only on `frame_start`. Changes to them between strobes have no effect on the current frame. A `line_start` in the same cycle as `frame_start` is ignored.
- R11: `line_addr` and `line_valid` update on the clock edge that samples `line_start`. `line_valid` is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Field/frame start strobe; samples the configuration |
| line_start | input | 1 | Output line strobe |
| base_a | input | 24 | Field base address one (odd field / woven frame) |
| base_b | input | 24 | Field base address two (even field) |
| size_word | input | 30 | Modulo, lines per field minus 1, words per line minus 1 |
| mode_word | input | 8 | bit0 enable, bit1 line doubling, bits3:2 pixel format |
| vid_out | input | 1 | Video output enable from sync configuration |
| aux_cfg | input | 8 | bit3 forces border colour |
| interlace | input | 1 | Interlaced scan enable |
| field_odd | input | 1 | Current field, 1 = odd |
| line_pos | input | 10 | Current raster line |
| retrace_line | input | 10 | Retrace start line |
| line_addr | output | 24 | Byte address of the presented row |
| line_valid | output | 1 | One-cycle pulse: `line_addr` is a row of this frame |
| line_words | output | 11 | 32-bit words per line |
| pix_fmt | output | 2 | Decoded pixel format |
| hres | output | 12 | Horizontal resolution in pixels |
| vres | output | 12 | Vertical resolution in rows |
| out_en | output | 1 | Display output enabled |
| border_force | output | 1 | Show border colour instead of pixels |

## Verification
The bench sweeps line widths, both modulo relations, all four formats, both scan types, both fields, both raster positions and doubling on and off. It follows every row of every frame through to the first strobe past the end. The sweep targets these faults and how each would show:

| Fault | Visible effect |
|---|---|
| Weave test not restricted to interlaced scan | A progressive frame with W = M gets the wrong stride |
| Missing retrace inversion | The wrong field base is picked when the strobe arrives late |
| Off-by-one in the modulo stride | Rows drift apart by four bytes per row |
| Doubling counter that never resets | Rows double unevenly from one frame to the next |

Directed cases cover two further faults. A design that latched configuration continuously would move the address in the middle of a frame. A design that let a line strobe win over a coincident frame strobe would emit a stale row.

// File: rtl/scan_pkg.sv
// Shared definitions for the scanout address generator.
// Assumes nothing beyond the bit layout of the mode and auxiliary words.
package scan_pkg;

    // Pixel format codes as carried in the mode word
    typedef enum logic [1:0] {
        FMT_1555 = 2'd0,
        FMT_565  = 2'd1,
        FMT_888  = 2'd2,
        FMT_8888 = 2'd3
    } pix_fmt_e;

    // Bit positions inside the mode word
    localparam int MODE_EN_BIT   = 0;
    localparam int MODE_DBL_BIT  = 1;
    localparam int MODE_FMT_LSB  = 2;

    // Bit position of the forced-border flag in the auxiliary word
    localparam int AUX_BLANK_BIT = 3;

    // Fallback resolutions used when the decoded value is too small
    localparam int HRES_DEFAULT  = 640;
    localparam int VRES_DEFAULT  = 480;
    localparam int RES_MIN       = 8;

endpackage

// File: rtl/scan_geom_decode.sv
// Combinational decode of the frame geometry.
// What it does: it turns the raw size word, mode word, base addresses and
// raster state into a start base, a row stride, a row count, the decoded
// format and the display resolution.
// What it assumes: the inputs are stable in the cycle in which the parent
// samples the outputs, which is the frame-start cycle.
module scan_geom_decode
    import scan_pkg::*;
#(
    parameter  int ADDR_W   = 24,
    parameter  int LINE_W   = 10,
    localparam int WORD_W   = LINE_W + 1,
    localparam int STRIDE_W = LINE_W + 4,
    localparam int ROW_W    = LINE_W + 2,
    localparam int RES_W    = LINE_W + 2
) (
    input  logic [3*LINE_W-1:0] size_word_i,
    input  logic [7:0]          mode_word_i,
    input  logic                vid_out_i,
    input  logic [7:0]          aux_cfg_i,
    input  logic                interlace_i,
    input  logic                field_odd_i,
    input  logic [LINE_W-1:0]   line_pos_i,
    input  logic [LINE_W-1:0]   retrace_line_i,
    input  logic [ADDR_W-1:0]   base_a_i,
    input  logic [ADDR_W-1:0]   base_b_i,
    output logic [ADDR_W-1:0]   start_base_o,
    output logic [STRIDE_W-1:0] stride_o,
    output logic [ROW_W-1:0]    rows_o,
    output logic [WORD_W-1:0]   words_o,
    output pix_fmt_e            fmt_o,
    output logic [RES_W-1:0]    hres_o,
    output logic [RES_W-1:0]    vres_o,
    output logic                dbl_o,
    output logic                en_o,
    output logic                border_o
);

    localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-2){1'b1}}, 2'b00};
    localparam int                SUM_W      = WORD_W + 1;

    logic [WORD_W-1:0] ppl;
    logic [WORD_W-1:0] lpf;
    logic [LINE_W-1:0] modulo;
    logic              weave;
    logic              odd_eff;
    logic [SUM_W-1:0]  row_words;
    logic [RES_W-1:0]  hres_raw;
    logic [RES_W:0]    ppl_x4;

    // Purpose: extract the three size fields and apply the plus-one offsets
    always_comb begin
        ppl    = WORD_W'(size_word_i[LINE_W-1:0]) + WORD_W'(1);
        lpf    = WORD_W'(size_word_i[2*LINE_W-1:LINE_W]) + WORD_W'(1);
        modulo = size_word_i[3*LINE_W-1:2*LINE_W];
    end

    // Purpose: detect the woven layout and pick the effective field
    always_comb begin
        weave   = interlace_i && (ppl == WORD_W'(modulo));
        odd_eff = field_odd_i ^ (line_pos_i >= retrace_line_i);
    end

    // Purpose: choose the word-aligned base address for this frame
    always_comb begin
        if (!interlace_i || weave || odd_eff) begin
            start_base_o = base_a_i & ALIGN_MASK;
        end else begin
            start_base_o = base_b_i & ALIGN_MASK;
        end
    end

    // Purpose: compute the row stride in bytes and the row count
    always_comb begin
        row_words = SUM_W'(ppl) + SUM_W'(modulo) - SUM_W'(1);
        if (weave) begin
            stride_o = {STRIDE_W'(ppl)} << 2;
            rows_o   = {lpf, 1'b0};
        end else begin
            stride_o = {row_words, 2'b00};
            rows_o   = ROW_W'(lpf);
        end
    end

    // Purpose: decode the pixel format and derive the raw horizontal size
    always_comb begin
        fmt_o  = pix_fmt_e'(mode_word_i[MODE_FMT_LSB +: 2]);
        ppl_x4 = (RES_W+1)'(ppl) << 2;
        unique case (fmt_o)
            FMT_1555,
            FMT_565:  hres_raw = RES_W'(ppl) << 1;
            FMT_888:  hres_raw = RES_W'(ppl_x4 / (RES_W+1)'(3));
            default:  hres_raw = RES_W'(ppl);
        endcase
    end

    // Purpose: substitute the default resolutions for undersized values
    always_comb begin
        hres_o = (hres_raw <= RES_W'(RES_MIN)) ? RES_W'(HRES_DEFAULT) : hres_raw;
        vres_o = (RES_W'(rows_o) <= RES_W'(RES_MIN)) ? RES_W'(VRES_DEFAULT)
                                                     : RES_W'(rows_o);
    end

    // Purpose: output enable, forced border and line doubling flags
    always_comb begin
        words_o  = ppl;
        dbl_o    = mode_word_i[MODE_DBL_BIT];
        en_o     = mode_word_i[MODE_EN_BIT] && vid_out_i;
        border_o = en_o && aux_cfg_i[AUX_BLANK_BIT];
    end

endmodule

// File: rtl/scan_row_stepper.sv
// Row address stepper.
// What it does: it holds the running row address and the row counter. On
// each accepted line strobe it presents the current row and then steps the
// address, or holds it for one more strobe when line doubling is on.
// What it assumes: the stride, the row count and the doubling flag are
// stable between loads. A load wins over a step in the same cycle.
module scan_row_stepper #(
    parameter int ADDR_W   = 24,
    parameter int STRIDE_W = 14,
    parameter int ROW_W    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                step_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [STRIDE_W-1:0] stride_i,
    input  logic [ROW_W-1:0]    rows_i,
    input  logic                dbl_i,
    output logic [ADDR_W-1:0]   line_addr_o,
    output logic                line_valid_o
);

    logic [ADDR_W-1:0] cur_q;
    logic [ROW_W-1:0]  row_q;
    logic              rep_q;
    logic              in_frame;
    logic              advance;

    // Purpose: decide whether rows remain and whether this strobe advances
    always_comb begin
        in_frame = (row_q < rows_i);
        advance  = !dbl_i || rep_q;
    end

    // Purpose: sequence the row address, counter and repeat phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q        <= '0;
            row_q        <= '0;
            rep_q        <= 1'b0;
            line_addr_o  <= '0;
            line_valid_o <= 1'b0;
        end else if (load_i) begin
            cur_q        <= base_i;
            row_q        <= '0;
            rep_q        <= 1'b0;
            line_valid_o <= 1'b0;
        end else if (step_i) begin
            line_valid_o <= in_frame;
            if (in_frame) begin
                line_addr_o <= cur_q;
                if (advance) begin
                    cur_q <= cur_q + ADDR_W'(stride_i);
                    row_q <= row_q + ROW_W'(1);
                    rep_q <= 1'b0;
                end else begin
                    rep_q <= 1'b1;
                end
            end
        end else begin
            line_valid_o <= 1'b0;
        end
    end

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid_o |-> (line_addr_o[1:0] == 2'b00)); // R2

    AST_ROW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        row_q <= rows_i); // R6

    AST_DOUBLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && dbl_i && !rep_q && in_frame) |=> (row_q == $past(row_q))); // R7

    AST_VALID_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid_o |-> ($past(step_i) && !$past(load_i))); // R11

    AST_FRAME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !line_valid_o); // R10

endmodule

// File: rtl/scan_addr_gen.sv
// Scanout line address generator, top level.
// What it does: it samples the display configuration on each frame-start
// strobe, keeps the decoded geometry for the whole frame and hands it to
// the row stepper, which answers every line strobe with a row address.
// What it assumes: the strobes are single-cycle pulses from the raster
// timing logic, and line_pos/field_odd are valid in the frame-start cycle.
module scan_addr_gen
    import scan_pkg::*;
#(
    parameter  int ADDR_W   = 24,
    parameter  int LINE_W   = 10,
    localparam int WORD_W   = LINE_W + 1,
    localparam int STRIDE_W = LINE_W + 4,
    localparam int ROW_W    = LINE_W + 2,
    localparam int RES_W    = LINE_W + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                line_start,
    input  logic [ADDR_W-1:0]   base_a,
    input  logic [ADDR_W-1:0]   base_b,
    input  logic [3*LINE_W-1:0] size_word,
    input  logic [7:0]          mode_word,
    input  logic                vid_out,
    input  logic [7:0]          aux_cfg,
    input  logic                interlace,
    input  logic                field_odd,
    input  logic [LINE_W-1:0]   line_pos,
    input  logic [LINE_W-1:0]   retrace_line,
    output logic [ADDR_W-1:0]   line_addr,
    output logic                line_valid,
    output logic [WORD_W-1:0]   line_words,
    output logic [1:0]          pix_fmt,
    output logic [RES_W-1:0]    hres,
    output logic [RES_W-1:0]    vres,
    output logic                out_en,
    output logic                border_force
);

    logic [ADDR_W-1:0]   dec_base;
    logic [STRIDE_W-1:0] dec_stride;
    logic [ROW_W-1:0]    dec_rows;
    logic [WORD_W-1:0]   dec_words;
    pix_fmt_e            dec_fmt;
    logic [RES_W-1:0]    dec_hres;
    logic [RES_W-1:0]    dec_vres;
    logic                dec_dbl;
    logic                dec_en;
    logic                dec_border;

    logic [STRIDE_W-1:0] stride_q;
    logic [ROW_W-1:0]    rows_q;
    logic [WORD_W-1:0]   words_q;
    pix_fmt_e            fmt_q;
    logic [RES_W-1:0]    hres_q;
    logic [RES_W-1:0]    vres_q;
    logic                dbl_q;
    logic                en_q;
    logic                border_q;

    scan_geom_decode #(
        .ADDR_W (ADDR_W),
        .LINE_W (LINE_W)
    ) u_decode (
        .size_word_i    (size_word),
        .mode_word_i    (mode_word),
        .vid_out_i      (vid_out),
        .aux_cfg_i      (aux_cfg),
        .interlace_i    (interlace),
        .field_odd_i    (field_odd),
        .line_pos_i     (line_pos),
        .retrace_line_i (retrace_line),
        .base_a_i       (base_a),
        .base_b_i       (base_b),
        .start_base_o   (dec_base),
        .stride_o       (dec_stride),
        .rows_o         (dec_rows),
        .words_o        (dec_words),
        .fmt_o          (dec_fmt),
        .hres_o         (dec_hres),
        .vres_o         (dec_vres),
        .dbl_o          (dec_dbl),
        .en_o           (dec_en),
        .border_o       (dec_border)
    );

    // Purpose: capture the decoded frame configuration on the frame strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stride_q <= '0;
            rows_q   <= '0;
            words_q  <= '0;
            fmt_q    <= FMT_1555;
            hres_q   <= '0;
            vres_q   <= '0;
            dbl_q    <= 1'b0;
            en_q     <= 1'b0;
            border_q <= 1'b0;
        end else if (frame_start) begin
            stride_q <= dec_stride;
            rows_q   <= dec_rows;
            words_q  <= dec_words;
            fmt_q    <= dec_fmt;
            hres_q   <= dec_hres;
            vres_q   <= dec_vres;
            dbl_q    <= dec_dbl;
            en_q     <= dec_en;
            border_q <= dec_border;
        end
    end

    scan_row_stepper #(
        .ADDR_W   (ADDR_W),
        .STRIDE_W (STRIDE_W),
        .ROW_W    (ROW_W)
    ) u_stepper (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (frame_start),
        .step_i       (line_start),
        .base_i       (dec_base),
        .stride_i     (stride_q),
        .rows_i       (rows_q),
        .dbl_i        (dbl_q),
        .line_addr_o  (line_addr),
        .line_valid_o (line_valid)
    );

    // Purpose: drive the frame-level outputs from the captured state
    always_comb begin
        line_words   = words_q;
        pix_fmt      = fmt_q;
        hres         = hres_q;
        vres         = vres_q;
        out_en       = en_q;
        border_force = border_q;
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(hres_q) && $stable(stride_q) && $stable(rows_q))); // R10

    AST_BORDER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(border_force) |-> out_en); // R9

endmodule

// File: tb/scan_addr_gen_tb.sv
module scan_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_start, line_start;
    logic [23:0] base_a, base_b;
    logic [29:0] size_word;
    logic [7:0]  mode_word, aux_cfg;
    logic        vid_out, interlace, field_odd;
    logic [9:0]  line_pos, retrace_line;
    logic [23:0] line_addr;
    logic        line_valid;
    logic [10:0] line_words;
    logic [1:0]  pix_fmt;
    logic [11:0] hres, vres;
    logic        out_en, border_force;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    scan_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
        .base_a(base_a), .base_b(base_b), .size_word(size_word), .mode_word(mode_word),
        .vid_out(vid_out), .aux_cfg(aux_cfg), .interlace(interlace), .field_odd(field_odd),
        .line_pos(line_pos), .retrace_line(retrace_line), .line_addr(line_addr),
        .line_valid(line_valid), .line_words(line_words), .pix_fmt(pix_fmt),
        .hres(hres), .vres(vres), .out_en(out_en), .border_force(border_force)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_frame();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
    endtask

    task automatic pulse_line();
        @(negedge clk) line_start = 1'b1;
        @(negedge clk) line_start = 1'b0;
    endtask

    function automatic int exp_hres(int ppl, int fmt);
        int h;
        case (fmt)
            0, 1:    h = ppl * 2;
            2:       h = (ppl * 4) / 3;
            default: h = ppl;
        endcase
        return (h <= 8) ? 640 : h;
    endfunction

    task automatic set_cfg(int ppl, int mdl, int lpf, int fmt, bit il, bit fld,
                           bit late, bit dbl);
        size_word    = {10'(mdl), 10'(lpf - 1), 10'(ppl - 1)};
        mode_word    = {4'b0, 2'(fmt), dbl, 1'b1};
        interlace    = il;
        field_odd    = fld;
        line_pos     = late ? 10'd300 : 10'd10;
        retrace_line = 10'd200;
    endtask

    // One full frame: configure, strobe, then every row and one past the end
    task automatic run_frame(int ppl, int mdl, int lpf, int fmt, bit il, bit fld,
                             bit late, bit dbl);
        bit          weave;
        int          stride, rows, reps, vexp;
        logic [23:0] base, exp_addr;
        string       tag;
        set_cfg(ppl, mdl, lpf, fmt, il, fld, late, dbl);
        weave = il && (ppl == mdl);
        if (weave) begin
            base = base_a & 24'hFFFFFC; stride = ppl * 4; rows = 2 * lpf; tag = "R5";
        end else begin
            stride = (ppl + mdl - 1) * 4; rows = lpf;
            if (!il) begin base = base_a & 24'hFFFFFC; tag = "R2"; end
            else if (fld ^ late) begin base = base_a & 24'hFFFFFC; tag = late ? "R4" : "R3"; end
            else begin base = base_b & 24'hFFFFFC; tag = late ? "R4" : "R3"; end
        end
        if (dbl) tag = "R7";
        reps = dbl ? 2 : 1;
        pulse_frame();
        chk("R8 fmt", 32'(pix_fmt), 32'(fmt));
        chk("R8 hres", 32'(hres), 32'(exp_hres(ppl, fmt)));
        vexp = (rows <= 8) ? 480 : rows;
        chk("R8 vres", 32'(vres), 32'(vexp));
        chk("R2 words", 32'(line_words), 32'(ppl));
        for (int k = 0; k <= rows * reps; k++) begin
            pulse_line();
            if (k < rows * reps) begin
                exp_addr = base + 24'((k / reps) * stride);
                chk({tag, " valid"}, 32'(line_valid), 32'd1);
                chk({tag, " addr"}, 32'(line_addr), 32'(exp_addr));
            end else begin
                chk("R6 past end", 32'(line_valid), 32'd0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int ppl_tab[3] = '{2, 5, 12};
        rst_n = 1'b0; frame_start = 1'b0; line_start = 1'b0;
        base_a = 24'hA12347; base_b = 24'hFFFFEE;
        size_word = '0; mode_word = '0; aux_cfg = '0; vid_out = 1'b1;
        interlace = 1'b0; field_odd = 1'b0; line_pos = '0; retrace_line = 10'd200;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid", 32'(line_valid), 32'd0);
        chk("R1 addr", 32'(line_addr), 32'd0);
        chk("R1 hres", 32'(hres), 32'd0);
        chk("R1 vres", 32'(vres), 32'd0);
        chk("R1 words", 32'(line_words), 32'd0);
        chk("R1 en", 32'({out_en, border_force, pix_fmt}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Main sweep over geometry, format, scan type, field and doubling
        for (int pi = 0; pi < 3; pi++)
            for (int me = 0; me < 2; me++)
                for (int fmt = 0; fmt < 4; fmt++)
                    for (int il = 0; il < 2; il++)
                        for (int fld = 0; fld < 2; fld++)
                            for (int late = 0; late < 2; late++)
                                for (int dbl = 0; dbl < 2; dbl++)
                                    run_frame(ppl_tab[pi],
                                              me ? ppl_tab[pi] : ppl_tab[pi] + 3,
                                              5, fmt, il[0], fld[0], late[0], dbl[0]);

        // R9: enable and forced-border combinations
        for (int c = 0; c < 8; c++) begin
            set_cfg(4, 4, 3, 3, 1'b0, 1'b0, 1'b0, 1'b0);
            mode_word[0] = c[0];
            vid_out      = c[1];
            aux_cfg      = c[2] ? 8'h08 : 8'hF7;
            pulse_frame();
            chk("R9 out_en", 32'(out_en), 32'(c[0] & c[1]));
            chk("R9 border", 32'(border_force), 32'(c[0] & c[1] & c[2]));
        end
        vid_out = 1'b1; aux_cfg = '0;

        // R10: mid-frame changes are ignored until the next frame strobe
        set_cfg(12, 15, 5, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        pulse_frame();
        pulse_line();
        chk("R10 first", 32'(line_addr), 32'h00A12344);
        base_a    = 24'h100000;
        size_word = {10'd2, 10'd9, 10'd1};
        mode_word = 8'h0D;
        pulse_line();
        chk("R10 held addr", 32'(line_addr), 32'h00A12344 + 32'd104);
        chk("R10 held hres", 32'(hres), 32'd24);
        chk("R10 held fmt", 32'(pix_fmt), 32'd0);
        // R10: coincident strobes, frame strobe wins and the line is dropped
        @(negedge clk) begin frame_start = 1'b1; line_start = 1'b1; end
        @(negedge clk) begin frame_start = 1'b0; line_start = 1'b0; end
        chk("R10 coincident", 32'(line_valid), 32'd0);
        chk("R10 new hres", 32'(hres), 32'd640);
        pulse_line();
        chk("R10 new base", 32'(line_addr), 32'h00100000);
        // R11: valid is a single-cycle pulse
        @(negedge clk);
        chk("R11 pulse", 32'(line_valid), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule